// File: doc/BRIEF.md
# Invalidation Descriptor Fetch and Dispatch Engine

This block is the consuming end of a ring of 128-bit invalidation descriptors in memory. Software places descriptors in the ring and moves a tail index forward. Whenever the head index differs from that tail, the engine reads the descriptor at the head. It decodes the 4-bit type held in the low word and turns it into a one-cycle command pulse. Each translation-related cache has its own pulse, and the pulse comes with the fields unpacked from that descriptor. A wait descriptor carries a status value and an address. When its status-write flag is set, the wait completes by handing a 32-bit write of that value to a write port. The engine does not raise an interrupt for it.

After each descriptor completes, the head moves on by one and wraps around the ring. Commands that have been dispatched but not yet acknowledged are counted. A wait descriptor with its fence flag set holds back its completion until that count is zero. A descriptor with an unknown type, or a read that returns an error, stops the engine. The fault flag then stays set and the head stays on the offending entry, so software can find it there. Only a reset clears the fault. Simple request/response, pulse and valid/ready ports stand in for the memory system and the caches.

Top module: `inv_dispatch`

## Requirements
- R1: After reset `head_idx` is 0, `fault` is 0, and `rd_req`, `st_valid` and all four command pulses are 0.
- R2: `rd_req` is raised, with `rd_idx` equal to `head_idx`, only when the engine is idle and `head_idx` differs from `tail_idx`. Only one read is outstanding at a time. While `head_idx` equals `tail_idx`, no read is made.
- R3: The type is low-word bits 3:0. Types 1, 2, 3 and 4 each raise exactly one pulse, on `ctx_inv`, `tlb_inv`, `dtlb_inv` and `iec_inv` respectively, in the cycle after the read response. The fields are taken from these bit positions (lo = bits 63:0 of `rd_data`, hi = bits 127:64), and every field that a type does not use reads 0:
  - Type 1: gran = lo[5:4], did = lo[31:16], sid = lo[47:32], fmask = lo[49:48].
  - Type 2: gran = lo[5:4], drain_wr = lo[6], drain_rd = lo[7], did = lo[31:16], amask = hi[5:0], hint = hi[6], page = hi[63:12].
  - Type 3: maxpend = lo[20:16], sid = lo[47:32], size = hi[0], page = hi[63:12].
  - Type 4: gran = {0, lo[4]}, imask = lo[31:27], iidx = lo[47:32].
- R4: The head advances by exactly one for each completed descriptor and wraps from DEPTH-1 to 0.
- R5: A type-5 (wait) descriptor with status-write lo[5] set raises `st_valid` with `st_data` = lo[63:32] and `st_addr` = {hi[63:2], 2'b00}. These hold steady until `st_ready`, and the head advances when the write is accepted. No read is made while the write is pending.
- R6: A wait descriptor with lo[5] clear completes with no status write. Its interrupt flag lo[4] has no effect.
- R7: When a wait descriptor has fence lo[6] set, its status write or completion waits until every earlier command pulse has been acknowledged on `cmd_ack`, one acknowledge per pulse. A wait descriptor without fence does not wait for acknowledges.
- R8: Type 0, types 6 to 15, or any nonzero reserved bit in lo[15:8] set `fault`. In that case no command or status write is made for the entry, the head stays on it, and no further read is made until reset.
- R9: A read response with `rd_err` set causes the same fault behaviour, and the head stays on the entry that was read.
- R10: No read is made while the count of unacknowledged commands, including one being issued, equals 2**PEND_W-1. Fetching resumes once acknowledges arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tail_idx | input | IDX_W | Producer index, one past the last valid entry |
| head_idx | output | IDX_W | Index of the next entry to consume |
| fault | output | 1 | Engine halted on a bad entry or a read error |
| rd_req | output | 1 | Descriptor read request (one cycle) |
| rd_idx | output | IDX_W | Ring index being read |
| rd_valid | input | 1 | Read response strobe |
| rd_err | input | 1 | Read response error |
| rd_data | input | 128 | Descriptor, low word in bits 63:0 |
| ctx_inv | output | 1 | Context-cache invalidate pulse |
| tlb_inv | output | 1 | Translation-cache invalidate pulse |
| dtlb_inv | output | 1 | Device translation-cache invalidate pulse |
| iec_inv | output | 1 | Interrupt-entry-cache invalidate pulse |
| cmd_gran | output | 2 | Granularity |
| cmd_did | output | 16 | Domain identifier |
| cmd_sid | output | 16 | Source identifier |
| cmd_fmask | output | 2 | Function mask |
| cmd_drain_rd | output | 1 | Drain reads |
| cmd_drain_wr | output | 1 | Drain writes |
| cmd_amask | output | 6 | Address mask |
| cmd_hint | output | 1 | Invalidation hint |
| cmd_page | output | 52 | Page-aligned address bits 63:12 |
| cmd_size | output | 1 | Size bit |
| cmd_maxpend | output | 5 | Maximum pending invalidations |
| cmd_imask | output | 5 | Interrupt index mask |
| cmd_iidx | output | 16 | Interrupt index |
| cmd_ack | input | 1 | One acknowledge per earlier command pulse |
| st_valid | output | 1 | Status write request |
| st_addr | output | 64 | Status write byte address (dword aligned) |
| st_data | output | 32 | Status write data |
| st_ready | input | 1 | Status write accepted |

## Verification
The hardest situation to reach is a fenced wait that must sit on the ring while command acknowledges are still owed. From the ports this means holding `cmd_ack` low on purpose, queuing a command ahead of the fenced wait, and then watching that neither the status write nor the head moves until the acknowledge is released. The same withheld-acknowledge control fills the outstanding-command counter to its limit, with a small PEND_W, to expose the fetch stall. Faults are provoked by placing a bad type, reserved bits or an injected read error at a known index and checking that the head stays there and that reads stop.

// File: rtl/inv_dispatch_pkg.sv
package inv_dispatch_pkg;

    localparam int unsigned DSC_W    = 128;
    localparam int unsigned ID_W     = 16;
    localparam int unsigned PAGE_W   = 52;
    localparam int unsigned AMASK_W  = 6;
    localparam int unsigned SMALL_W  = 5;
    localparam int unsigned SDATA_W  = 32;
    localparam int unsigned SADDR_W  = 62;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_CTX  = 3'd1,
        K_TLB  = 3'd2,
        K_DTLB = 3'd3,
        K_IEC  = 3'd4,
        K_WAIT = 3'd5,
        K_BAD  = 3'd7
    } kind_e;

    typedef struct packed {
        logic [1:0]         gran;
        logic [ID_W-1:0]    did;
        logic [ID_W-1:0]    sid;
        logic [1:0]         fmask;
        logic               drain_rd;
        logic               drain_wr;
        logic [AMASK_W-1:0] amask;
        logic               hint;
        logic [PAGE_W-1:0]  page;
        logic               size;
        logic [SMALL_W-1:0] maxpend;
        logic [SMALL_W-1:0] imask;
        logic [ID_W-1:0]    iidx;
    } cmd_fields_t;

    typedef struct packed {
        logic               sw;
        logic               fence;
        logic [SDATA_W-1:0] sdata;
        logic [SADDR_W-1:0] saddr;
    } wait_fields_t;

    typedef struct packed {
        kind_e        kind;
        cmd_fields_t  f;
        wait_fields_t w;
    } dsc_t;

    function automatic kind_e kind_of(input logic [3:0] code);
        case (code)
            4'd1:    return K_CTX;
            4'd2:    return K_TLB;
            4'd3:    return K_DTLB;
            4'd4:    return K_IEC;
            4'd5:    return K_WAIT;
            default: return K_BAD;
        endcase
    endfunction

endpackage

// File: rtl/inv_desc_decode.sv
module inv_desc_decode
    import inv_dispatch_pkg::*;
(
    input  logic [DSC_W-1:0] raw,
    output dsc_t             dsc
);
    logic [63:0] lo;
    logic [63:0] hi;

    assign lo = raw[63:0];
    assign hi = raw[127:64];

    always_comb begin
        dsc = '0;
        dsc.kind = (lo[15:8] != 8'h00) ? K_BAD : kind_of(lo[3:0]);
        case (dsc.kind)
            K_CTX: begin
                dsc.f.gran  = lo[5:4];
                dsc.f.did   = lo[31:16];
                dsc.f.sid   = lo[47:32];
                dsc.f.fmask = lo[49:48];
            end
            K_TLB: begin
                dsc.f.gran     = lo[5:4];
                dsc.f.drain_wr = lo[6];
                dsc.f.drain_rd = lo[7];
                dsc.f.did      = lo[31:16];
                dsc.f.amask    = hi[5:0];
                dsc.f.hint     = hi[6];
                dsc.f.page     = hi[63:12];
            end
            K_DTLB: begin
                dsc.f.maxpend = lo[20:16];
                dsc.f.sid     = lo[47:32];
                dsc.f.size    = hi[0];
                dsc.f.page    = hi[63:12];
            end
            K_IEC: begin
                dsc.f.gran  = {1'b0, lo[4]};
                dsc.f.imask = lo[31:27];
                dsc.f.iidx  = lo[47:32];
            end
            K_WAIT: begin
                dsc.w.sw    = lo[5];
                dsc.w.fence = lo[6];
                dsc.w.sdata = lo[63:32];
                dsc.w.saddr = hi[63:2];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/inv_pend_count.sv
module inv_pend_count #(
    parameter int unsigned PEND_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic zero,
    output logic full
);
    localparam logic [PEND_W-1:0] CNT_MAX  = '1;
    localparam logic [PEND_W-1:0] CNT_NEAR = CNT_MAX - 1'b1;

    logic [PEND_W-1:0] cnt;
    logic              dec_ok;

    assign dec_ok = dec && ((cnt != '0) || inc);
    assign zero   = (cnt == '0) && !inc;
    assign full   = (cnt == CNT_MAX) || ((cnt == CNT_NEAR) && inc);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case ({inc, dec_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX) |-> !inc);

    p_zero_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (zero && !inc && !dec) |=> zero || inc);
endmodule

// File: rtl/inv_ring_ptr.sv
module inv_ring_ptr #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (step) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (step && idx == LAST) |=> idx == '0);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(idx));
endmodule

// File: rtl/inv_dispatch.sv
module inv_dispatch
    import inv_dispatch_pkg::*;
#(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned PEND_W = 4,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  tail_idx,
    output logic [IDX_W-1:0]  head_idx,
    output logic              fault,
    output logic              rd_req,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_valid,
    input  logic              rd_err,
    input  logic [127:0]      rd_data,
    output logic              ctx_inv,
    output logic              tlb_inv,
    output logic              dtlb_inv,
    output logic              iec_inv,
    output logic [1:0]        cmd_gran,
    output logic [15:0]       cmd_did,
    output logic [15:0]       cmd_sid,
    output logic [1:0]        cmd_fmask,
    output logic              cmd_drain_rd,
    output logic              cmd_drain_wr,
    output logic [5:0]        cmd_amask,
    output logic              cmd_hint,
    output logic [51:0]       cmd_page,
    output logic              cmd_size,
    output logic [4:0]        cmd_maxpend,
    output logic [4:0]        cmd_imask,
    output logic [15:0]       cmd_iidx,
    input  logic              cmd_ack,
    output logic              st_valid,
    output logic [63:0]       st_addr,
    output logic [31:0]       st_data,
    input  logic              st_ready
);
    typedef enum logic [2:0] {
        S_IDLE, S_RD, S_FENCE, S_STWR, S_HALT
    } state_e;

    state_e       state;
    dsc_t         dsc;
    cmd_fields_t  fields_q;
    wait_fields_t wait_q;
    logic [3:0]   pulse_q;
    logic         pulse_any;
    logic         pend_zero;
    logic         pend_full;
    logic         step;
    logic         rsp_ok;
    logic         wait_stalls;

    inv_desc_decode u_decode (
        .raw (rd_data),
        .dsc (dsc)
    );

    inv_pend_count #(.PEND_W(PEND_W)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .inc  (pulse_any),
        .dec  (cmd_ack),
        .zero (pend_zero),
        .full (pend_full)
    );

    inv_ring_ptr #(.DEPTH(DEPTH)) u_head (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .idx  (head_idx)
    );

    assign pulse_any   = |pulse_q;
    assign rsp_ok      = (state == S_RD) && rd_valid && !rd_err && (dsc.kind != K_BAD);
    assign wait_stalls = (dsc.w.fence && !pend_zero) || dsc.w.sw;

    always_comb begin
        step = 1'b0;
        case (state)
            S_RD:    step = rsp_ok && !((dsc.kind == K_WAIT) && wait_stalls);
            S_FENCE: step = pend_zero && !wait_q.sw;
            S_STWR:  step = st_ready;
            default: step = 1'b0;
        endcase
    end

    assign rd_req   = (state == S_IDLE) && (head_idx != tail_idx) && !pend_full;
    assign rd_idx   = head_idx;
    assign fault    = (state == S_HALT);
    assign st_valid = (state == S_STWR);
    assign st_addr  = {wait_q.saddr, 2'b00};
    assign st_data  = wait_q.sdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            pulse_q  <= '0;
            fields_q <= '0;
            wait_q   <= '0;
        end else begin
            pulse_q <= '0;
            case (state)
                S_IDLE: begin
                    if (rd_req) state <= S_RD;
                end
                S_RD: begin
                    if (rd_valid) begin
                        if (rd_err || dsc.kind == K_BAD) begin
                            state <= S_HALT;
                        end else if (dsc.kind == K_WAIT) begin
                            wait_q <= dsc.w;
                            if (dsc.w.fence && !pend_zero) state <= S_FENCE;
                            else if (dsc.w.sw)              state <= S_STWR;
                            else                            state <= S_IDLE;
                        end else begin
                            fields_q <= dsc.f;
                            case (dsc.kind)
                                K_CTX:   pulse_q <= 4'b0001;
                                K_TLB:   pulse_q <= 4'b0010;
                                K_DTLB:  pulse_q <= 4'b0100;
                                default: pulse_q <= 4'b1000;
                            endcase
                            state <= S_IDLE;
                        end
                    end
                end
                S_FENCE: begin
                    if (pend_zero) state <= wait_q.sw ? S_STWR : S_IDLE;
                end
                S_STWR: begin
                    if (st_ready) state <= S_IDLE;
                end
                default: state <= S_HALT;
            endcase
        end
    end

    assign ctx_inv      = pulse_q[0];
    assign tlb_inv      = pulse_q[1];
    assign dtlb_inv     = pulse_q[2];
    assign iec_inv      = pulse_q[3];
    assign cmd_gran     = fields_q.gran;
    assign cmd_did      = fields_q.did;
    assign cmd_sid      = fields_q.sid;
    assign cmd_fmask    = fields_q.fmask;
    assign cmd_drain_rd = fields_q.drain_rd;
    assign cmd_drain_wr = fields_q.drain_wr;
    assign cmd_amask    = fields_q.amask;
    assign cmd_hint     = fields_q.hint;
    assign cmd_page     = fields_q.page;
    assign cmd_size     = fields_q.size;
    assign cmd_maxpend  = fields_q.maxpend;
    assign cmd_imask    = fields_q.imask;
    assign cmd_iidx     = fields_q.iidx;

    p_single_read_r2: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    p_one_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctx_inv, tlb_inv, dtlb_inv, iec_inv}));

    p_st_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready) |=> st_valid && $stable(st_data) && $stable(st_addr));

    p_st_no_read_r5: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> !rd_req);

    p_fence_r7: assert property (@(posedge clk) disable iff (rst)
        (st_valid && wait_q.fence) |-> pend_zero);

    p_fault_hold_r8: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault && $stable(head_idx) && !rd_req);
endmodule

// File: tb/inv_dispatch_bench.sv
module inv_dispatch_bench;
    localparam int DEPTH = 16;
    localparam int IW    = $clog2(DEPTH);
    localparam int PW    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [IW-1:0] tail_idx = '0;
    logic [IW-1:0] head_idx, rd_idx;
    logic fault, rd_req;
    logic rd_valid = 1'b0, rd_err = 1'b0;
    logic [127:0] rd_data = '0;
    logic ctx_inv, tlb_inv, dtlb_inv, iec_inv;
    logic [1:0] cmd_gran, cmd_fmask;
    logic [15:0] cmd_did, cmd_sid, cmd_iidx;
    logic cmd_drain_rd, cmd_drain_wr, cmd_hint, cmd_size;
    logic [5:0] cmd_amask;
    logic [51:0] cmd_page;
    logic [4:0] cmd_maxpend, cmd_imask;
    logic cmd_ack = 1'b0;
    logic st_valid, st_ready;
    logic [63:0] st_addr;
    logic [31:0] st_data;

    inv_dispatch #(.DEPTH(DEPTH), .PEND_W(PW)) u_inv_dispatch (
        .clk(clk), .rst(rst), .tail_idx(tail_idx), .head_idx(head_idx), .fault(fault),
        .rd_req(rd_req), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data),
        .ctx_inv(ctx_inv), .tlb_inv(tlb_inv), .dtlb_inv(dtlb_inv), .iec_inv(iec_inv),
        .cmd_gran(cmd_gran), .cmd_did(cmd_did), .cmd_sid(cmd_sid), .cmd_fmask(cmd_fmask),
        .cmd_drain_rd(cmd_drain_rd), .cmd_drain_wr(cmd_drain_wr), .cmd_amask(cmd_amask),
        .cmd_hint(cmd_hint), .cmd_page(cmd_page), .cmd_size(cmd_size), .cmd_maxpend(cmd_maxpend),
        .cmd_imask(cmd_imask), .cmd_iidx(cmd_iidx), .cmd_ack(cmd_ack),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready)
    );

    logic [127:0] mem [DEPTH];
    int err_idx = -1;
    bit ack_hold = 1'b0;
    int owe = 0;
    int st_delay = 0;
    int st_wait = 0;
    int checks = 0, fails = 0;
    logic [130:0] sbq [$];
    int wp = 0;
    int req_cnt = 0, pulse_cnt = 0, fault_req = 0, stw_req = 0, st_cnt = 0;
    logic any_pulse;
    assign any_pulse = ctx_inv | tlb_inv | dtlb_inv | iec_inv;

    // memory model: one-cycle read latency, optional error on one index
    always @(posedge clk) begin
        rd_valid <= rd_req;
        rd_err   <= rd_req && (int'(rd_idx) == err_idx);
        rd_data  <= mem[rd_idx];
    end

    // command acknowledger: one ack per pulse, withheld while ack_hold
    always @(posedge clk) begin : acker
        int give;
        give = (!ack_hold && owe > 0) ? 1 : 0;
        if (rst) begin
            owe     <= 0;
            cmd_ack <= 1'b0;
        end else begin
            cmd_ack <= (give != 0);
            owe     <= owe + (any_pulse ? 1 : 0) - give;
        end
    end

    always @(posedge clk) st_wait <= (st_valid && !st_ready) ? st_wait + 1 : 0;
    assign st_ready = st_valid && (st_wait >= st_delay);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic compare(input logic [130:0] obs, input string req);
        logic [130:0] e;
        checks++;
        if (sbq.size() == 0) begin
            fails++;
            $display("FAIL %s unexpected output: actual 0x%0h expected none", req, obs);
        end else begin
            e = sbq.pop_front();
            if (obs !== e) begin
                fails++;
                $display("FAIL %s output mismatch: actual 0x%0h expected 0x%0h", req, obs, e);
            end
        end
    endtask

    // monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_req) req_cnt++;
            if (fault && rd_req) fault_req++;
            if (st_valid && rd_req) stw_req++;
            if (any_pulse) begin
                pulse_cnt++;
                compare({(ctx_inv ? 3'd1 : tlb_inv ? 3'd2 : dtlb_inv ? 3'd3 : 3'd4), 4'b0,
                         cmd_gran, cmd_did, cmd_sid, cmd_fmask, cmd_drain_rd, cmd_drain_wr,
                         cmd_amask, cmd_hint, cmd_page, cmd_size, cmd_maxpend, cmd_imask,
                         cmd_iidx}, "R3");
            end
            if (st_valid && st_ready) begin
                st_cnt++;
                compare({3'd5, 32'b0, st_addr, st_data}, "R5");
            end
        end
    end

    // expected result of a descriptor, computed from the field positions in the requirements
    function automatic logic [130:0] exp_item(input logic [63:0] lo, input logic [63:0] hi);
        logic [123:0] p;
        case (lo[3:0])
            4'd1: p = {lo[5:4], lo[31:16], lo[47:32], lo[49:48], 2'b0, 6'b0, 1'b0, 52'b0, 1'b0, 5'b0, 5'b0, 16'b0};
            4'd2: p = {lo[5:4], lo[31:16], 16'b0, 2'b0, lo[7], lo[6], hi[5:0], hi[6], hi[63:12], 1'b0, 5'b0, 5'b0, 16'b0};
            4'd3: p = {2'b0, 16'b0, lo[47:32], 2'b0, 2'b0, 6'b0, 1'b0, hi[63:12], hi[0], lo[20:16], 5'b0, 16'b0};
            4'd4: p = {1'b0, lo[4], 16'b0, 16'b0, 2'b0, 2'b0, 6'b0, 1'b0, 52'b0, 1'b0, 5'b0, lo[31:27], lo[47:32]};
            default: p = '0;
        endcase
        if (lo[3:0] == 4'd5)
            return lo[5] ? {3'd5, 32'b0, hi[63:2], 2'b00, lo[63:32]} : '0;
        return {lo[2:0], 4'b0, p};
    endfunction

    function automatic logic [127:0] mk_ctx(input logic [1:0] g, input logic [15:0] did,
                                            input logic [15:0] sid, input logic [1:0] fm);
        return {64'b0, 14'b0, fm, sid, did, 10'b0, g, 4'd1};
    endfunction
    function automatic logic [127:0] mk_tlb(input logic [1:0] g, input logic dr, input logic dw,
                                            input logic [15:0] did, input logic [5:0] am,
                                            input logic ih, input logic [51:0] pg);
        return {pg, 5'b0, ih, am, 32'b0, did, 8'b0, dr, dw, g, 4'd2};
    endfunction
    function automatic logic [127:0] mk_dtlb(input logic [15:0] sid, input logic [4:0] mp,
                                             input logic [51:0] pg, input logic s);
        return {pg, 11'b0, s, 16'b0, sid, 11'b0, mp, 12'b0, 4'd3};
    endfunction
    function automatic logic [127:0] mk_iec(input logic g, input logic [4:0] im, input logic [15:0] idx);
        return {64'b0, 16'b0, idx, im, 22'b0, g, 4'd4};
    endfunction
    function automatic logic [127:0] mk_wait(input logic [31:0] sd, input logic fn, input logic sw,
                                             input logic ifl, input logic [61:0] sa);
        return {sa, 2'b0, sd, 25'b0, fn, sw, ifl, 4'd5};
    endfunction

    // driver: writes the ring and pushes the expected result
    task automatic add(input logic [127:0] d, input bit expect_out);
        logic [130:0] e;
        mem[wp] = d;
        e = exp_item(d[63:0], d[127:64]);
        if (expect_out && e[130:128] != 3'd0) sbq.push_back(e);
        wp = (wp + 1) % DEPTH;
    endtask

    task automatic publish();
        @(negedge clk);
        tail_idx = IW'(wp);
    endtask

    task automatic drain();
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (head_idx == tail_idx && sbq.size() == 0 && !st_valid) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tail_idx = '0;
        wp = 0;
        sbq.delete();
        err_idx = -1;
        ack_hold = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int r, h, p0, s0;
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(head_idx == '0, "R1", "head after reset", head_idx, 0);
        chk(!fault, "R1", "fault after reset", fault, 0);
        chk(!rd_req && !st_valid && !any_pulse, "R1", "outputs idle after reset",
            {rd_req, st_valid, any_pulse}, 0);

        // R2 no read while head equals tail
        r = req_cnt;
        repeat (10) @(negedge clk);
        chk(req_cnt == r, "R2", "reads with empty ring", req_cnt - r, 0);

        // R3 each command type, several field patterns
        add(mk_ctx(2'b01, 16'h1234, 16'hbeef, 2'b10), 1);
        add(mk_tlb(2'b11, 1'b1, 1'b0, 16'h00a5, 6'h09, 1'b1, 52'h1_2345_6789_abcd), 1);
        add(mk_dtlb(16'h0f0f, 5'h1b, 52'hf_edcb_a987_6543, 1'b1), 1);
        add(mk_iec(1'b1, 5'h1f, 16'h8001), 1);
        add(mk_ctx(2'b11, 16'hffff, 16'h0001, 2'b11), 1);
        add(mk_tlb(2'b10, 1'b0, 1'b1, 16'h5a5a, 6'h3f, 1'b0, 52'h0_0000_0000_0001), 1);
        publish();
        drain();
        chk(head_idx == IW'(wp), "R4", "head after first batch", head_idx, wp);
        chk(sbq.size() == 0, "R3", "commands outstanding", sbq.size(), 0);

        // R5 status write with back-pressure
        st_delay = 3;
        add(mk_dtlb(16'h2222, 5'h01, 52'h0_0000_1111_2222, 1'b0), 1);
        add(mk_wait(32'hcafe_0001, 1'b0, 1'b1, 1'b0, 62'h0123_4567_89ab_cdef), 1);
        add(mk_iec(1'b0, 5'h03, 16'h0042), 1);
        publish();
        drain();
        chk(sbq.size() == 0, "R5", "status write outstanding", sbq.size(), 0);
        chk(stw_req == 0, "R5", "reads during status write", stw_req, 0);
        st_delay = 0;

        // R6 wait without status write, interrupt flag set
        s0 = st_cnt;
        add(mk_wait(32'h1111_2222, 1'b0, 1'b0, 1'b1, 62'h55), 1);
        publish();
        drain();
        chk(head_idx == IW'(wp), "R6", "head after silent wait", head_idx, wp);
        chk(st_cnt == s0, "R6", "status writes from silent wait", st_cnt - s0, 0);

        // R4 wraparound across the ring end
        for (int i = 0; i < 8; i++) add(mk_iec(i[0], 5'(i), 16'(i * 3 + 1)), 1);
        publish();
        drain();
        for (int i = 0; i < 8; i++) add(mk_dtlb(16'(i + 100), 5'(i), 52'(i * 7), i[1]), 1);
        publish();
        drain();
        chk(head_idx == IW'(wp), "R4", "head after wrap", head_idx, wp);
        chk(sbq.size() == 0, "R4", "items left after wrap", sbq.size(), 0);

        // R7 fenced wait holds until acks arrive
        ack_hold = 1'b1;
        add(mk_ctx(2'b10, 16'h0777, 16'h0888, 2'b01), 1);
        h = wp;
        add(mk_wait(32'hd00d_0007, 1'b1, 1'b1, 1'b0, 62'h3_0000_0040), 1);
        publish();
        repeat (30) @(negedge clk);
        chk(!st_valid, "R7", "status write before ack", st_valid, 0);
        chk(head_idx == IW'(h), "R7", "head held at fenced wait", head_idx, h);
        ack_hold = 1'b0;
        drain();
        chk(sbq.size() == 0 && head_idx == IW'(wp), "R7", "fenced wait completion", sbq.size(), 0);
        repeat (10) @(negedge clk);

        // R7 unfenced wait does not wait for acks
        ack_hold = 1'b1;
        add(mk_ctx(2'b01, 16'h0101, 16'h0202, 2'b00), 1);
        add(mk_wait(32'h0000_beef, 1'b0, 1'b1, 1'b0, 62'h44), 1);
        publish();
        repeat (30) @(negedge clk);
        chk(sbq.size() == 0, "R7", "unfenced write with acks held", sbq.size(), 0);
        ack_hold = 1'b0;
        repeat (10) @(negedge clk);

        // R10 outstanding limit stalls fetch
        ack_hold = 1'b1;
        p0 = pulse_cnt;
        h = wp;
        for (int i = 0; i < 10; i++) add(mk_iec(1'b1, 5'h00, 16'(16'h0200 + i)), 1);
        publish();
        repeat (60) @(negedge clk);
        chk(pulse_cnt - p0 == 7, "R10", "commands issued at limit", pulse_cnt - p0, 7);
        chk(head_idx == IW'((h + 7) % DEPTH), "R10", "head at limit", head_idx, (h + 7) % DEPTH);
        ack_hold = 1'b0;
        drain();
        chk(pulse_cnt - p0 == 10, "R10", "commands after release", pulse_cnt - p0, 10);

        // R8 unknown type 7
        do_reset();
        add(mk_ctx(2'b01, 16'h0a0a, 16'h0b0b, 2'b01), 1);
        add({64'h0, 64'h0000_0000_0000_0007}, 0);
        add(mk_ctx(2'b10, 16'h0c0c, 16'h0d0d, 2'b10), 0);
        publish();
        repeat (40) @(negedge clk);
        chk(fault, "R8", "fault on type 7", fault, 1);
        chk(head_idx == IW'(1), "R8", "head on bad entry", head_idx, 1);
        chk(sbq.size() == 0 && pulse_cnt >= 0, "R8", "only first command issued", sbq.size(), 0);
        p0 = pulse_cnt;
        repeat (10) @(negedge clk);
        chk(fault_req == 0 && pulse_cnt == p0 && head_idx == IW'(1), "R8", "halt holds",
            fault_req, 0);

        // R8 type 0 at the first entry
        do_reset();
        add({64'hffff, 64'h0}, 0);
        publish();
        repeat (20) @(negedge clk);
        chk(fault && head_idx == '0, "R8", "fault on type 0", {fault, head_idx}, 5'h10);

        // R8 reserved bits set on an otherwise valid type
        do_reset();
        add(mk_iec(1'b0, 5'h01, 16'h0001) | 128'h100, 0);
        publish();
        repeat (20) @(negedge clk);
        chk(fault && head_idx == '0, "R8", "fault on reserved bits", {fault, head_idx}, 5'h10);

        // R9 read error
        do_reset();
        err_idx = 2;
        add(mk_ctx(2'b01, 16'h0001, 16'h0002, 2'b00), 1);
        add(mk_tlb(2'b01, 1'b0, 1'b0, 16'h0003, 6'h00, 1'b0, 52'h10), 1);
        add(mk_ctx(2'b01, 16'h0004, 16'h0005, 2'b00), 0);
        add(mk_ctx(2'b01, 16'h0006, 16'h0007, 2'b00), 0);
        publish();
        repeat (40) @(negedge clk);
        chk(fault && head_idx == IW'(2), "R9", "fault and head on read error",
            {fault, head_idx}, {1'b1, 4'd2});
        chk(sbq.size() == 0 && fault_req == 0, "R9", "no work after read error", sbq.size(), 0);

        summary();
        $finish;
    end
endmodule